// File: doc/BRIEF.md
# Flash Program/Erase Timing Sequencer

This block drives the control strobes of a non-volatile memory macro for four kinds of high-voltage operation: programming a single 32-bit word, programming a run of sequential words during one high-voltage period, erasing one page, and erasing the whole array. Every setup, pulse, hold and recovery step takes a programmable number of ticks. Two external tick inputs supply the time base: a microsecond tick for most steps, and a millisecond tick for the two erase pulses. The block does not generate its own ticks.

Software starts an operation with a one-cycle command carrying a one-hot operation field, a byte address and a data word. During a multi-word row program, the block pulses a next-word event each time it is ready for another word. It keeps the program and store strobes high while it waits. If no word arrives within a fixed number of microsecond ticks, the row ends and a timeout event is raised. An abort bit sends any running operation into a safe wind-down, in which the store strobe is never released before the high-voltage strobe.

A lock status follows two active-low system requests, safe-state and shutdown. While it is set, every command is refused with an error pulse, which is meant to become a bus error response.

Top module: `fseq_top`

## Requirements
- R1: The operation field has bit 0 for word program, bit 1 for row program, bit 2 for page erase, bit 3 for mass erase and bit 4 for abort. When idle, the lowest set bit among bits 0 to 3 selects the operation. An abort bit alone while idle has no effect.
- R2: A word program follows this sequence, with each step lasting until its count of microsecond ticks has been seen and then one more cycle, so that a count of 0 gives a one-cycle step:
  - the program strobe rises and the block waits the setup count;
  - the store strobe rises and the block waits the program-setup count;
  - the column strobe is held for the program count;
  - the program strobe falls and the block waits the hold count;
  - the store strobe falls and the block waits the recovery count.
- R3: A page erase raises the erase strobe for the setup count. The store strobe is then held for the page-erase count of millisecond ticks, and the sequence continues with hold and recovery as in R2. A mass erase uses the mass-erase count and the second hold count.
- R4: A row program waits after each word with the program and store strobes high and pulses the next-word event once. A next-word strobe restarts the column pulse with the word index incremented by one and the new data. If 32 (TMO_TICKS) microsecond ticks pass with no new word, the block pulses the timeout event and goes to hold and recovery.
- R5: The done event pulses for one cycle as the block returns to idle after every operation, including one that was aborted.
- R6: Busy is high exactly while an operation is in progress, and no strobe is high while busy is low.
- R7: Lock is a registered OR of the two active-low requests and is 1 in reset. While lock is set, any command with a non-zero operation field pulses the error output in the next cycle and starts or aborts nothing.
- R8: A program or page-erase command is refused with the error pulse, and nothing starts, when any of the following holds:
  - address bits [1:0] are not zero;
  - the bank field [31:30] is not 01 (bank 0) or 10 (bank 1);
  - any bit of [29:ADDR_W] is set.

  Mass erase does not check the address.
- R9: While busy, a command without the abort bit has no effect.
- R10: An abort behaves according to the step the block is in:
  - during the first setup step, it goes straight to recovery;
  - during the store-active steps, it goes to hold and then recovery;
  - during hold or recovery, it is ignored.
- R11: The store strobe rises only after a cycle with the program or erase strobe high, and falls only after both have been low for a cycle. The column strobe is high only with both program and store high, and program and erase are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| usTick | input | 1 | Microsecond tick pulse |
| msTick | input | 1 | Millisecond tick pulse |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 5 | One-hot operation field (see R1) |
| cmdAddr | input | 32 | Byte address with bank field |
| cmdData | input | 32 | First data word |
| nextValid | input | 1 | Next row word present |
| nextData | input | 32 | Next row word |
| safeReqN | input | 1 | Safe-state request, active low |
| shutReqN | input | 1 | Shutdown request, active low |
| tNvs | input | 8 | Strobe-to-store setup, us |
| tPgs | input | 8 | Store-to-program setup, us |
| tProg | input | 8 | Program pulse, us |
| tNvh | input | 8 | Store hold, us |
| tNvh1 | input | 8 | Store hold after mass erase, us |
| tRcv | input | 8 | Recovery, us |
| tErase | input | 8 | Page erase pulse, ms |
| tMe | input | 8 | Mass erase pulse, ms |
| flProg | output | 1 | Program strobe |
| flErase | output | 1 | Erase strobe |
| flNvstr | output | 1 | Store strobe |
| flYe | output | 1 | Column strobe |
| flBank | output | 2 | Latched bank field |
| flAddr | output | 9 | Latched word index |
| flData | output | 32 | Latched data word |
| busy | output | 1 | Operation in progress |
| lock | output | 1 | Write/erase lock |
| doneEvt | output | 1 | Completion pulse |
| nextEvt | output | 1 | Next-word pulse |
| timeoutEvt | output | 1 | Row timeout pulse |
| cmdErr | output | 1 | Command refused pulse |

## Verification
The bench runs a word program under the default counts and again with every count at zero. The first run separates tick-counted steps; the second exposes any step that takes longer than one cycle when its count is zero. The bench drives multi-bit operation fields and an abort-only field to pin down the priority order. It also runs a row program with two serviced words followed by an unserviced wait, which distinguishes the next-word path from the timeout path. Aborts are placed in the setup, column-pulse and erase-pulse steps, and bad addresses, locked commands and commands issued while busy show whether refusals leave the strobes untouched. Every cycle, all outputs are compared with a behavioural model driven by the same tick pattern.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_NVS, ST_PGM, ST_WNEXT, ST_ERS, ST_HOLD, ST_RCV
  } seqState_t;

  typedef enum logic [1:0] {
    OP_WORD, OP_ROW, OP_PAGE, OP_MASS
  } opKind_t;

  typedef enum logic [2:0] {
    IV_NVS, IV_PGS, IV_PROG, IV_NVH, IV_NVH1, IV_RCV, IV_ERASE, IV_ME
  } ivSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic   load;      // reload interval counter
    ivSel_t sel;       // which interval to load
    logic   useMs;     // count millisecond ticks
    logic   tmoClr;    // hold row timeout counter at zero
    logic   latchCmd;  // capture command address/data
    logic   latchNext; // advance word index, capture next data
  } dpCtl_t;

endpackage

// File: rtl/fseq_dp.sv
module fseq_dp
  import fseq_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 32,
  parameter int TMO_TICKS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtl_t              ctl,
  input  logic                usTick,
  input  logic                msTick,
  input  logic [CNT_W-1:0]    tNvs,
  input  logic [CNT_W-1:0]    tPgs,
  input  logic [CNT_W-1:0]    tProg,
  input  logic [CNT_W-1:0]    tNvh,
  input  logic [CNT_W-1:0]    tNvh1,
  input  logic [CNT_W-1:0]    tRcv,
  input  logic [CNT_W-1:0]    tErase,
  input  logic [CNT_W-1:0]    tMe,
  input  logic [31:0]         cmdAddr,
  input  logic [DATA_W-1:0]   cmdData,
  input  logic [DATA_W-1:0]   nextData,
  output logic                addrOk,
  output logic                cntZero,
  output logic                tmoHit,
  output logic [1:0]          flBank,
  output logic [ADDR_W-3:0]   flAddr,
  output logic [DATA_W-1:0]   flData
);

  localparam int TMO_W = $clog2(TMO_TICKS + 1);
  localparam logic [TMO_W-1:0] TMO_LIM = TMO_W'(TMO_TICKS);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ivVal;
  logic [TMO_W-1:0] tmo;
  logic             tick;

  always_comb begin
    unique case (ctl.sel)
      IV_NVS:   ivVal = tNvs;
      IV_PGS:   ivVal = tPgs;
      IV_PROG:  ivVal = tProg;
      IV_NVH:   ivVal = tNvh;
      IV_NVH1:  ivVal = tNvh1;
      IV_RCV:   ivVal = tRcv;
      IV_ERASE: ivVal = tErase;
      IV_ME:    ivVal = tMe;
      default:  ivVal = '0;
    endcase
  end

  assign tick    = ctl.useMs ? msTick : usTick;
  assign cntZero = (cnt == '0);
  assign tmoHit  = (tmo == TMO_LIM);
  assign addrOk  = (cmdAddr[1:0] == 2'b00) &&
                   (cmdAddr[31:30] == 2'b01 || cmdAddr[31:30] == 2'b10) &&
                   (cmdAddr[29:ADDR_W] == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.load) begin
      cnt <= ivVal;
    end else if (!cntZero && tick) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmo <= '0;
    end else if (ctl.tmoClr) begin
      tmo <= '0;
    end else if (usTick && !tmoHit) begin
      tmo <= tmo + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flBank <= '0;
      flAddr <= '0;
      flData <= '0;
    end else if (ctl.latchCmd) begin
      flBank <= cmdAddr[31:30];
      flAddr <= cmdAddr[ADDR_W-1:2];
      flData <= cmdData;
    end else if (ctl.latchNext) begin
      flAddr <= flAddr + 1'b1;
      flData <= nextData;
    end
  end

  AST_TMO_NEVER_PAST_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    tmoHit |=> (tmoHit || tmo == '0)) else $error("row timeout counter overran"); // R4

endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [4:0] cmdOp,
  input  logic       addrOk,
  input  logic       nextValid,
  input  logic       safeReqN,
  input  logic       shutReqN,
  input  logic       cntZero,
  input  logic       tmoHit,
  output dpCtl_t     ctl,
  output logic       flProg,
  output logic       flErase,
  output logic       flNvstr,
  output logic       flYe,
  output logic       busy,
  output logic       lock,
  output logic       doneEvt,
  output logic       nextEvt,
  output logic       timeoutEvt,
  output logic       cmdErr
);

  seqState_t state, stateD;
  opKind_t   opQ, opD, pickOp;
  logic      lockQ;
  logic      doneD, nextD, tmoD, errD;
  logic      stopReq, pickValid, isProg;

  assign isProg = (opQ == OP_WORD) || (opQ == OP_ROW);
  assign pickValid = |cmdOp[3:0];
  assign stopReq = cmdValid && cmdOp[4] && !lockQ &&
                   (state inside {ST_SETUP, ST_NVS, ST_PGM, ST_WNEXT, ST_ERS});

  always_comb begin
    if (cmdOp[0])      pickOp = OP_WORD;
    else if (cmdOp[1]) pickOp = OP_ROW;
    else if (cmdOp[2]) pickOp = OP_PAGE;
    else               pickOp = OP_MASS;
  end

  always_comb begin
    stateD        = state;
    opD           = opQ;
    ctl.load      = 1'b0;
    ctl.sel       = IV_NVS;
    ctl.useMs     = (state == ST_ERS);
    ctl.tmoClr    = (state != ST_WNEXT);
    ctl.latchCmd  = 1'b0;
    ctl.latchNext = 1'b0;
    doneD         = 1'b0;
    nextD         = 1'b0;
    tmoD          = 1'b0;
    errD          = cmdValid && (|cmdOp) && lockQ;
    if (state == ST_IDLE) begin
      if (cmdValid && !lockQ && pickValid) begin
        if (pickOp != OP_MASS && !addrOk) begin
          errD = 1'b1;
        end else begin
          stateD       = ST_SETUP;
          opD          = pickOp;
          ctl.load     = 1'b1;
          ctl.sel      = IV_NVS;
          ctl.latchCmd = 1'b1;
        end
      end
    end else if (stopReq) begin
      ctl.load = 1'b1;
      if (state == ST_SETUP) begin
        stateD  = ST_RCV;
        ctl.sel = IV_RCV;
      end else begin
        stateD  = ST_HOLD;
        ctl.sel = (opQ == OP_MASS) ? IV_NVH1 : IV_NVH;
      end
    end else begin
      unique case (state)
        ST_SETUP: if (cntZero) begin
          ctl.load = 1'b1;
          if (isProg) begin
            stateD  = ST_NVS;
            ctl.sel = IV_PGS;
          end else begin
            stateD  = ST_ERS;
            ctl.sel = (opQ == OP_PAGE) ? IV_ERASE : IV_ME;
          end
        end
        ST_NVS: if (cntZero) begin
          stateD   = ST_PGM;
          ctl.load = 1'b1;
          ctl.sel  = IV_PROG;
        end
        ST_PGM: if (cntZero) begin
          if (opQ == OP_ROW) begin
            stateD = ST_WNEXT;
            nextD  = 1'b1;
          end else begin
            stateD   = ST_HOLD;
            ctl.load = 1'b1;
            ctl.sel  = IV_NVH;
          end
        end
        ST_WNEXT: if (nextValid) begin
          stateD        = ST_PGM;
          ctl.load      = 1'b1;
          ctl.sel       = IV_PROG;
          ctl.latchNext = 1'b1;
        end else if (tmoHit) begin
          stateD   = ST_HOLD;
          ctl.load = 1'b1;
          ctl.sel  = IV_NVH;
          tmoD     = 1'b1;
        end
        ST_ERS: if (cntZero) begin
          stateD   = ST_HOLD;
          ctl.load = 1'b1;
          ctl.sel  = (opQ == OP_MASS) ? IV_NVH1 : IV_NVH;
        end
        ST_HOLD: if (cntZero) begin
          stateD   = ST_RCV;
          ctl.load = 1'b1;
          ctl.sel  = IV_RCV;
        end
        ST_RCV: if (cntZero) begin
          stateD = ST_IDLE;
          doneD  = 1'b1;
        end
        default: stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      opQ        <= OP_WORD;
      lockQ      <= 1'b1;
      doneEvt    <= 1'b0;
      nextEvt    <= 1'b0;
      timeoutEvt <= 1'b0;
      cmdErr     <= 1'b0;
    end else begin
      state      <= stateD;
      opQ        <= opD;
      lockQ      <= !safeReqN || !shutReqN;
      doneEvt    <= doneD;
      nextEvt    <= nextD;
      timeoutEvt <= tmoD;
      cmdErr     <= errD;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign lock    = lockQ;
  assign flProg  = isProg && (state inside {ST_SETUP, ST_NVS, ST_PGM, ST_WNEXT});
  assign flErase = !isProg && (state inside {ST_SETUP, ST_ERS});
  assign flNvstr = state inside {ST_NVS, ST_PGM, ST_WNEXT, ST_ERS, ST_HOLD};
  assign flYe    = (state == ST_PGM);

  AST_STROBES_NEED_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (flProg || flErase || flNvstr || flYe) |-> busy) else $error("strobe while idle"); // R6
  AST_NVSTR_AFTER_HV: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flNvstr) |-> $past(flProg || flErase)) else $error("store rose first"); // R11
  AST_HV_DROPS_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flNvstr) |-> ($past(!flProg && !flErase) && !flProg && !flErase)) else $error("store fell early"); // R10
  AST_YE_FRAMED: assert property (@(posedge clk) disable iff (!rstN)
    flYe |-> (flProg && flNvstr)) else $error("column strobe unframed"); // R2
  AST_NO_DUAL_HV: assert property (@(posedge clk) disable iff (!rstN)
    !(flProg && flErase)) else $error("program and erase together"); // R11
  AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    doneEvt |-> (!busy && $past(busy))) else $error("done without operation"); // R5
  AST_LOCK_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (lock && !busy) |=> !busy) else $error("start while locked"); // R7

endmodule

// File: rtl/fseq_top.sv
module fseq_top
  import fseq_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 32,
  parameter int TMO_TICKS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usTick,
  input  logic              msTick,
  input  logic              cmdValid,
  input  logic [4:0]        cmdOp,
  input  logic [31:0]       cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              nextValid,
  input  logic [DATA_W-1:0] nextData,
  input  logic              safeReqN,
  input  logic              shutReqN,
  input  logic [CNT_W-1:0]  tNvs,
  input  logic [CNT_W-1:0]  tPgs,
  input  logic [CNT_W-1:0]  tProg,
  input  logic [CNT_W-1:0]  tNvh,
  input  logic [CNT_W-1:0]  tNvh1,
  input  logic [CNT_W-1:0]  tRcv,
  input  logic [CNT_W-1:0]  tErase,
  input  logic [CNT_W-1:0]  tMe,
  output logic              flProg,
  output logic              flErase,
  output logic              flNvstr,
  output logic              flYe,
  output logic [1:0]        flBank,
  output logic [ADDR_W-3:0] flAddr,
  output logic [DATA_W-1:0] flData,
  output logic              busy,
  output logic              lock,
  output logic              doneEvt,
  output logic              nextEvt,
  output logic              timeoutEvt,
  output logic              cmdErr
);

  dpCtl_t ctl;
  logic   addrOk, cntZero, tmoHit;

  fseq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .addrOk(addrOk),
    .nextValid(nextValid), .safeReqN(safeReqN), .shutReqN(shutReqN),
    .cntZero(cntZero), .tmoHit(tmoHit), .ctl(ctl),
    .flProg(flProg), .flErase(flErase), .flNvstr(flNvstr), .flYe(flYe),
    .busy(busy), .lock(lock), .doneEvt(doneEvt), .nextEvt(nextEvt),
    .timeoutEvt(timeoutEvt), .cmdErr(cmdErr)
  );

  fseq_dp #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMO_TICKS(TMO_TICKS)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .usTick(usTick), .msTick(msTick),
    .tNvs(tNvs), .tPgs(tPgs), .tProg(tProg), .tNvh(tNvh), .tNvh1(tNvh1),
    .tRcv(tRcv), .tErase(tErase), .tMe(tMe),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .nextData(nextData),
    .addrOk(addrOk), .cntZero(cntZero), .tmoHit(tmoHit),
    .flBank(flBank), .flAddr(flAddr), .flData(flData)
  );

endmodule

// File: tb/test_fseq_top.sv
`timescale 1ns/1ps
module test_fseq_top;

  localparam int TMO = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        usTick = 1'b0, msTick = 1'b0;
  logic        cmdValid = 1'b0;
  logic [4:0]  cmdOp = '0;
  logic [31:0] cmdAddr = '0, cmdData = '0;
  logic        nextValid = 1'b0;
  logic [31:0] nextData = '0;
  logic        safeReqN = 1'b1, shutReqN = 1'b1;
  logic [7:0]  tNvs = 8'd2, tPgs = 8'd1, tProg = 8'd3, tNvh = 8'd2;
  logic [7:0]  tNvh1 = 8'd4, tRcv = 8'd1, tErase = 8'd2, tMe = 8'd3;

  logic        flProg, flErase, flNvstr, flYe, busy, lock;
  logic        doneEvt, nextEvt, timeoutEvt, cmdErr;
  logic [1:0]  flBank;
  logic [8:0]  flAddr;
  logic [31:0] flData;

  fseq_top i_fseq_top (
    .clk(clk), .rstN(rstN), .usTick(usTick), .msTick(msTick),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .nextValid(nextValid), .nextData(nextData), .safeReqN(safeReqN), .shutReqN(shutReqN),
    .tNvs(tNvs), .tPgs(tPgs), .tProg(tProg), .tNvh(tNvh), .tNvh1(tNvh1),
    .tRcv(tRcv), .tErase(tErase), .tMe(tMe),
    .flProg(flProg), .flErase(flErase), .flNvstr(flNvstr), .flYe(flYe),
    .flBank(flBank), .flAddr(flAddr), .flData(flData), .busy(busy), .lock(lock),
    .doneEvt(doneEvt), .nextEvt(nextEvt), .timeoutEvt(timeoutEvt), .cmdErr(cmdErr)
  );

  always #4 clk = ~clk; // 125 MHz

  int    checks = 0, failures = 0, cyc = 0, doneSeen = 0;
  string curReq = "R6";

  // Tick pattern: microsecond every 3 cycles, millisecond every 11
  always @(negedge clk) begin
    cyc++;
    usTick <= (cyc % 3 == 0);
    msTick <= (cyc % 11 == 0);
  end

  // Behavioural reference: phases 0 idle,1 setup,2 store setup,3 column,
  // 4 row wait,5 erase pulse,6 hold,7 recovery; kind 0 word,1 row,2 page,3 mass
  int          mPh, mRem, mKind, mTmo;
  logic        mLock, mDone, mNext, mTout, mErr;
  logic [1:0]  mBank;
  logic [8:0]  mAddr;
  logic [31:0] mData;

  function automatic int holdVal(int k);
    return (k == 3) ? int'(tNvh1) : int'(tNvh);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPh = 0; mRem = 0; mKind = 0; mTmo = 0; mLock = 1'b1;
      mDone = 0; mNext = 0; mTout = 0; mErr = 0;
      mBank = '0; mAddr = '0; mData = '0;
    end else begin
      logic acted, lockOld;
      int pick;
      lockOld = mLock;
      mLock = !safeReqN || !shutReqN;
      mDone = 0; mNext = 0; mTout = 0; mErr = 0; acted = 0;
      if (cmdValid && cmdOp != 0 && lockOld) mErr = 1;
      pick = cmdOp[0] ? 0 : cmdOp[1] ? 1 : cmdOp[2] ? 2 : cmdOp[3] ? 3 : -1;
      if (mPh == 0) begin
        if (cmdValid && !lockOld && pick >= 0) begin
          if (pick != 3 && !(cmdAddr[1:0] == 0 && (cmdAddr[31:30] == 2'b01 ||
              cmdAddr[31:30] == 2'b10) && cmdAddr[29:11] == 0)) mErr = 1;
          else begin
            mPh = 1; mRem = tNvs; mKind = pick;
            mBank = cmdAddr[31:30]; mAddr = cmdAddr[10:2]; mData = cmdData;
          end
        end
        acted = 1;
      end else if (cmdValid && cmdOp[4] && !lockOld && mPh <= 5) begin
        if (mPh == 1) begin mPh = 7; mRem = tRcv; end
        else begin mPh = 6; mRem = holdVal(mKind); end
        acted = 1;
      end
      if (!acted) begin
        case (mPh)
          1: if (mRem == 0) begin
               if (mKind < 2) begin mPh = 2; mRem = tPgs; end
               else begin mPh = 5; mRem = (mKind == 2) ? tErase : tMe; end
             end else if (usTick) mRem--;
          2: if (mRem == 0) begin mPh = 3; mRem = tProg; end else if (usTick) mRem--;
          3: if (mRem == 0) begin
               if (mKind == 1) begin mPh = 4; mTmo = 0; mNext = 1; end
               else begin mPh = 6; mRem = tNvh; end
             end else if (usTick) mRem--;
          4: if (nextValid) begin mPh = 3; mRem = tProg; mAddr = mAddr + 1; mData = nextData; end
             else if (mTmo == TMO) begin mPh = 6; mRem = tNvh; mTout = 1; end
             else if (usTick) mTmo++;
          5: if (mRem == 0) begin mPh = 6; mRem = holdVal(mKind); end
             else if (msTick) mRem--;
          6: if (mRem == 0) begin mPh = 7; mRem = tRcv; end else if (usTick) mRem--;
          7: if (mRem == 0) begin mPh = 0; mDone = 1; end else if (usTick) mRem--;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string field, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s during %s at %0t: actual=%h expected=%h", req, field, curReq, $time, act, exp);
    end
  endtask

  // Compare every cycle, away from the rising edge
  always @(negedge clk) begin
    chk("flProg",  "R2", flProg,  (mPh >= 1 && mPh <= 4 && mKind < 2));
    chk("flErase", "R3", flErase, ((mPh == 1 || mPh == 5) && mKind >= 2));
    chk("flNvstr", "R11", flNvstr, (mPh >= 2 && mPh <= 6));
    chk("flYe",    "R2", flYe,    (mPh == 3));
    chk("busy",    "R6", busy,    (mPh != 0));
    chk("lock",    "R7", lock,    mLock);
    chk("doneEvt", "R5", doneEvt, mDone);
    chk("nextEvt", "R4", nextEvt, mNext);
    chk("timeoutEvt", "R4", timeoutEvt, mTout);
    chk("cmdErr",  "R8", cmdErr,  mErr);
    chk("flAddr",  "R4", flAddr,  mAddr);
    chk("flBank",  "R8", flBank,  mBank);
    chk("flData",  "R4", flData,  mData);
    if (doneEvt) doneSeen++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic issue(logic [4:0] op, logic [31:0] addr, logic [31:0] data);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = addr; cmdData = data;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = '0;
  endtask

  task automatic waitIdle();
    while (mPh != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic waitPh(int ph);
    while (mPh != ph) @(negedge clk);
  endtask

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    curReq = "R7 reset";
    chk("lock@reset", "R7", lock, 1'b1);
    chk("busy@reset", "R6", busy, 1'b0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    curReq = "R2 word program";
    d0 = doneSeen;
    issue(5'b00001, 32'h4000_0124, 32'hA5A5_0001);
    waitIdle();
    chk("done count", "R5", doneSeen - d0, 1);

    curReq = "R1 abort alone idle";
    issue(5'b10000, 32'h4000_0000, 32'h0);
    repeat (3) @(negedge clk);
    chk("busy after abort-only", "R1", busy, 1'b0);

    curReq = "R1 R4 priority row program";
    issue(5'b00110, 32'h8000_0040, 32'h1111_0000);
    for (int w = 0; w < 2; w++) begin
      waitPh(4);
      repeat (2) @(negedge clk);
      nextValid = 1'b1; nextData = 32'h2222_0000 + w;
      @(negedge clk);
      nextValid = 1'b0;
    end
    waitIdle();
    chk("row word index", "R4", flAddr, 9'h012);

    curReq = "R3 page erase";
    issue(5'b00100, 32'h4000_0200, 32'h0);
    waitIdle();
    curReq = "R3 mass erase, address unchecked";
    issue(5'b01000, 32'hFFFF_FFFF, 32'h0);
    waitIdle();

    curReq = "R8 bad addresses";
    issue(5'b00001, 32'h4000_0002, 32'h0);
    issue(5'b00001, 32'h0000_0004, 32'h0);
    issue(5'b00100, 32'hC000_0004, 32'h0);
    issue(5'b00001, 32'h4000_1000, 32'h0);
    repeat (2) @(negedge clk);
    chk("busy after bad address", "R8", busy, 1'b0);

    curReq = "R7 lock refusal";
    safeReqN = 1'b0;
    repeat (2) @(negedge clk);
    issue(5'b00001, 32'h4000_0000, 32'h0);
    issue(5'b10000, 32'h4000_0000, 32'h0);
    safeReqN = 1'b1; shutReqN = 1'b0;
    repeat (2) @(negedge clk);
    issue(5'b01000, 32'h4000_0000, 32'h0);
    repeat (2) @(negedge clk);
    chk("busy while locked", "R7", busy, 1'b0);
    shutReqN = 1'b1;
    repeat (2) @(negedge clk);

    curReq = "R9 command while busy";
    issue(5'b00001, 32'h4000_0010, 32'h3333_3333);
    waitPh(2);
    issue(5'b00100, 32'h8000_0000, 32'h4444_4444);
    chk("data kept while busy", "R9", flData, 32'h3333_3333);
    waitIdle();

    curReq = "R10 abort in setup";
    issue(5'b00001, 32'h4000_0020, 32'h0);
    issue(5'b10000, 32'h0, 32'h0);
    waitIdle();
    curReq = "R10 abort in column pulse";
    issue(5'b00010, 32'h4000_0020, 32'h0);
    waitPh(3);
    issue(5'b10000, 32'h0, 32'h0);
    waitIdle();
    curReq = "R10 abort in mass erase pulse";
    issue(5'b01000, 32'h0, 32'h0);
    waitPh(5);
    issue(5'b10000, 32'h0, 32'h0);
    waitIdle();

    curReq = "R2 zero counts";
    tNvs = 0; tPgs = 0; tProg = 0; tNvh = 0; tRcv = 0;
    issue(5'b00001, 32'h4000_0030, 32'h5555_5555);
    waitIdle();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule